// File: doc/BRIEF.md
# Continuation-Memory Fibonacci Engine

This block returns the Fibonacci number of a small unsigned argument by running the naive doubly recursive definition, with no call stack in hardware. Every pending piece of work is a continuation record written into a local memory. A record names one of three things to do next. A final record means "hand the value out". A first-half record holds the original argument and a parent pointer. A second-half record holds the first partial sum and a parent pointer. Between records the engine holds one current call. That call either evaluates the function for a number under a continuation pointer, or applies a loaded continuation to a value.

The user presents an argument on `arg` and pulses `start` while the engine is idle. `busy` is high while the engine works. `done` pulses for one cycle when `fib_out` is valid, and `fib_out` then holds its value until the next accepted start. Records are allocated by a pointer that moves up by one on every write. The pointer is cleared on every accepted start, and no record is freed. The memory depth therefore bounds the largest argument, and an elaboration check enforces that bound. An argument of zero, or one above the configured maximum, is refused: the engine answers with zero and raises `arg_err`.

Top module: `fibcont_engine`

## Requirements
- R1: While `rst_n` is low and after its release, `done`, `busy`, `arg_err` are 0 and `fib_out` is 0.
- R2: For any argument from 1 to N_MAX, `fib_out` equals fib(arg) with fib(1)=fib(2)=1 and fib(k)=fib(k-1)+fib(k-2), and `arg_err` is 0.
- R3: `done` is high for exactly one cycle per accepted start. `fib_out` and `arg_err` keep their values until the next accepted start.
- R4: For a legal argument, `done` is high after rising edge number 6*fib(arg)-2, counting the edge that accepts `start` as edge 1 (4 for arguments 1 and 2).
- R5: `busy` is high from the cycle after a legal start is accepted up to, but not including, the cycle in which `done` is high, and is 0 while `done` is high.
- R6: A `start` pulse with any argument while `busy` is high is ignored. The running job keeps its result and its latency.
- R7: An argument of 0 or above N_MAX gives `done`=1, `fib_out`=0 and `arg_err`=1 right after the accepting edge, and `busy` stays 0.
- R8: A `start` raised in the cycle where `done` is high is accepted as a new job.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request a computation; sampled only when idle |
| arg | input | ARG_W | Argument n |
| busy | output | 1 | Computation in progress |
| done | output | 1 | One-cycle pulse: result valid |
| arg_err | output | 1 | Last accepted argument was refused |
| fib_out | output | RES_W | Result, held until the next accepted start |

## Verification
Completion and acceptance of a new job can fall in the same cycle. The engine returns to idle in the cycle that `done` is high, so a `start` seen there begins the next job at once. The bench raises `start` in exactly the cycle where it first observes `done`. It then judges the second job by its own result and its own edge count, both computed from the latency formula. A second overlap, a `start` arriving while a job runs, is provoked in the middle of a long computation. It is judged by an unchanged result and an unchanged latency of the original job.

// File: rtl/fibc_pkg.sv
package fibc_pkg;

   // Continuation kinds kept in the top two bits of each record.
   typedef enum logic [1:0] {
      CK_FINAL  = 2'd0,
      CK_FIRST  = 2'd1,
      CK_SECOND = 2'd2
   } cont_kind_e;

   // Current call: evaluate a number, or apply the held continuation.
   typedef enum logic {
      CALL_EVAL  = 1'b0,
      CALL_APPLY = 1'b1
   } call_kind_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RUN  = 2'd1,
      ST_LOAD = 2'd2
   } seq_state_e;

   // Iterative Fibonacci, used for elaboration-time sizing checks.
   function automatic longint unsigned fib_of(input int unsigned k);
      longint unsigned a = 1;
      longint unsigned b = 1;
      longint unsigned t;
      if (k == 0) return 0;
      for (int unsigned i = 3; i <= k; i++) begin
         t = a + b;
         a = b;
         b = t;
      end
      return b;
   endfunction

endpackage

// File: rtl/fibc_cont_mem.sv
module fibc_cont_mem #(
   parameter int WIDTH = 27,
   parameter int DEPTH = 512,
   parameter int AW    = 9
) (
   input  logic             clk,
   input  logic             we,
   input  logic [AW-1:0]    waddr,
   input  logic [WIDTH-1:0] wdata,
   input  logic             re,
   input  logic [AW-1:0]    raddr,
   output logic [WIDTH-1:0] rdata
);

   logic [WIDTH-1:0] cells [DEPTH];

   always_ff @(posedge clk) begin
      if (we) cells[waddr] <= wdata;
      if (re) rdata <= cells[raddr];
   end

endmodule

// File: rtl/fibc_bump_alloc.sv
module fibc_bump_alloc #(
   parameter int AW = 9
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clear,
   input  logic          take,
   output logic [AW-1:0] addr
);

   logic [AW-1:0] next_q;
   logic [AW-1:0] base;

   assign base = clear ? '0 : next_q;
   assign addr = base;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    next_q <= '0;
      else if (take) next_q <= base + AW'(1);
   end

endmodule

// File: rtl/fibc_seq.sv
module fibc_seq
   import fibc_pkg::*;
#(
   parameter int ARG_W = 4,
   parameter int RES_W = 16,
   parameter int AW    = 9,
   parameter int N_MAX = 13,
   localparam int REC_W = 2 + RES_W + AW
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [ARG_W-1:0] arg,
   output logic             busy,
   output logic             done,
   output logic             arg_err,
   output logic [RES_W-1:0] fib_out,
   output logic             mem_we,
   output logic [REC_W-1:0] mem_wdata,
   output logic             mem_re,
   output logic [AW-1:0]    mem_raddr,
   input  logic [REC_W-1:0] mem_rdata,
   output logic             alloc_clear,
   output logic             alloc_take,
   input  logic [AW-1:0]    alloc_addr
);

   localparam logic [ARG_W-1:0] ARG_LIM = ARG_W'(N_MAX);

   seq_state_e       state_q;
   call_kind_e       call_q;
   logic [RES_W-1:0] num_q;    // argument when evaluating, value when applying
   logic [AW-1:0]    ptr_q;    // continuation pointer of an evaluate call
   logic [REC_W-1:0] cont_q;   // continuation being applied

   cont_kind_e       c_kind;
   logic [RES_W-1:0] c_val;
   logic [AW-1:0]    c_ptr;
   logic             arg_ok;
   logic             is_leaf;

   assign c_kind  = cont_kind_e'(cont_q[REC_W-1 -: 2]);
   assign c_val   = cont_q[AW +: RES_W];
   assign c_ptr   = cont_q[0 +: AW];
   assign arg_ok  = (arg != '0) && (arg <= ARG_LIM);
   assign is_leaf = (num_q <= RES_W'(2));
   assign busy    = (state_q != ST_IDLE);

   // Memory and allocator requests for the current cycle.
   always_comb begin
      mem_we      = 1'b0;
      mem_wdata   = '0;
      mem_re      = 1'b0;
      mem_raddr   = ptr_q;
      alloc_clear = 1'b0;
      alloc_take  = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            if (start && arg_ok) begin
               alloc_clear = 1'b1;
               alloc_take  = 1'b1;
               mem_we      = 1'b1;
               mem_wdata   = {CK_FINAL, {RES_W{1'b0}}, {AW{1'b0}}};
            end
         end
         ST_RUN: begin
            if (call_q == CALL_EVAL) begin
               if (is_leaf) begin
                  mem_re    = 1'b1;
                  mem_raddr = ptr_q;
               end else begin
                  mem_we     = 1'b1;
                  alloc_take = 1'b1;
                  mem_wdata  = {CK_FIRST, num_q, ptr_q};
               end
            end else begin
               if (c_kind == CK_FIRST) begin
                  mem_we     = 1'b1;
                  alloc_take = 1'b1;
                  mem_wdata  = {CK_SECOND, num_q, c_ptr};
               end else if (c_kind == CK_SECOND) begin
                  mem_re    = 1'b1;
                  mem_raddr = c_ptr;
               end
            end
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         call_q  <= CALL_EVAL;
         num_q   <= '0;
         ptr_q   <= '0;
         cont_q  <= '0;
         done    <= 1'b0;
         arg_err <= 1'b0;
         fib_out <= '0;
      end else begin
         done <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (start) begin
                  if (arg_ok) begin
                     state_q <= ST_RUN;
                     call_q  <= CALL_EVAL;
                     num_q   <= RES_W'(arg);
                     ptr_q   <= alloc_addr;
                     arg_err <= 1'b0;
                  end else begin
                     done    <= 1'b1;
                     arg_err <= 1'b1;
                     fib_out <= '0;
                  end
               end
            end
            ST_RUN: begin
               if (call_q == CALL_EVAL) begin
                  if (is_leaf) begin
                     num_q   <= RES_W'(1);
                     state_q <= ST_LOAD;
                  end else begin
                     num_q <= num_q - RES_W'(1);
                     ptr_q <= alloc_addr;
                  end
               end else begin
                  unique case (c_kind)
                     CK_FIRST: begin
                        call_q <= CALL_EVAL;
                        num_q  <= c_val - RES_W'(2);
                        ptr_q  <= alloc_addr;
                     end
                     CK_SECOND: begin
                        num_q   <= c_val + num_q;
                        state_q <= ST_LOAD;
                     end
                     default: begin
                        fib_out <= num_q;
                        done    <= 1'b1;
                        state_q <= ST_IDLE;
                     end
                  endcase
               end
            end
            ST_LOAD: begin
               cont_q  <= mem_rdata;
               call_q  <= CALL_APPLY;
               state_q <= ST_RUN;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/fibcont_engine.sv
module fibcont_engine
   import fibc_pkg::*;
#(
   parameter int ARG_W = 4,
   parameter int RES_W = 16,
   parameter int DEPTH = 512,
   parameter int N_MAX = 13,
   localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int REC_W = 2 + RES_W + AW
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [ARG_W-1:0] arg,
   output logic             busy,
   output logic             done,
   output logic             arg_err,
   output logic [RES_W-1:0] fib_out
);

   // Elaboration checks on the configuration.
   if (RES_W < ARG_W) begin : g_bad_res_w
      $error("RES_W must be at least ARG_W");
   end
   if (N_MAX < 1 || N_MAX >= (1 << ARG_W)) begin : g_bad_nmax
      $error("N_MAX must be in 1 .. 2**ARG_W-1");
   end
   if (longint'(DEPTH) < 2 * fib_of(N_MAX) - 1) begin : g_bad_depth
      $error("DEPTH too small for 2*fib(N_MAX)-1 records");
   end
   if (fib_of(N_MAX) >= (longint'(1) << RES_W)) begin : g_bad_width
      $error("RES_W cannot hold fib(N_MAX)");
   end

   logic             mem_we;
   logic [REC_W-1:0] mem_wdata;
   logic             mem_re;
   logic [AW-1:0]    mem_raddr;
   logic [REC_W-1:0] mem_rdata;
   logic             alloc_clear;
   logic             alloc_take;
   logic [AW-1:0]    alloc_addr;

   fibc_seq #(
      .ARG_W (ARG_W),
      .RES_W (RES_W),
      .AW    (AW),
      .N_MAX (N_MAX)
   ) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (start),
      .arg         (arg),
      .busy        (busy),
      .done        (done),
      .arg_err     (arg_err),
      .fib_out     (fib_out),
      .mem_we      (mem_we),
      .mem_wdata   (mem_wdata),
      .mem_re      (mem_re),
      .mem_raddr   (mem_raddr),
      .mem_rdata   (mem_rdata),
      .alloc_clear (alloc_clear),
      .alloc_take  (alloc_take),
      .alloc_addr  (alloc_addr)
   );

   fibc_bump_alloc #(.AW(AW)) u_alloc (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (alloc_clear),
      .take  (alloc_take),
      .addr  (alloc_addr)
   );

   fibc_cont_mem #(
      .WIDTH (REC_W),
      .DEPTH (DEPTH),
      .AW    (AW)
   ) u_mem (
      .clk   (clk),
      .we    (mem_we),
      .waddr (alloc_addr),
      .wdata (mem_wdata),
      .re    (mem_re),
      .raddr (mem_raddr),
      .rdata (mem_rdata)
   );

endmodule

// File: rtl/fibc_engine_chk.sv
module fibc_engine_chk #(
   parameter int RES_W = 16,
   parameter int AW    = 9
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start,
   input logic             busy,
   input logic             done,
   input logic             arg_err,
   input logic [RES_W-1:0] fib_out,
   input logic             mem_we,
   input logic [AW-1:0]    alloc_addr
);

   p_done_not_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   p_busy_until_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> (busy || done));

   p_idle_stays_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start) |=> !busy);

   p_done_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !start) |=> !done);

   p_result_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> $stable(fib_out));

   p_err_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      arg_err |-> (fib_out == '0));

   // Records of one job land at consecutive addresses (R2 relies on it).
   p_alloc_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |=> (alloc_addr == $past(alloc_addr) + AW'(1)));

endmodule

bind fibcont_engine fibc_engine_chk #(
   .RES_W (RES_W),
   .AW    (AW)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .start      (start),
   .busy       (busy),
   .done       (done),
   .arg_err    (arg_err),
   .fib_out    (fib_out),
   .mem_we     (mem_we),
   .alloc_addr (alloc_addr)
);

// File: tb/sim_fibcont_engine.sv
module sim_fibcont_engine;

   localparam int ARG_W = 4;
   localparam int RES_W = 16;
   localparam int DEPTH = 512;
   localparam int N_MAX = 13;
   localparam int NV    = 8;

   // {argument, expected fib, expected latency 6*fib-2}
   localparam int VEC [NV][3] = '{
      '{1, 1, 4}, '{2, 1, 4}, '{3, 2, 10}, '{4, 3, 16},
      '{5, 5, 28}, '{7, 13, 76}, '{10, 55, 328}, '{13, 233, 1396}
   };

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             start = 1'b0;
   logic [ARG_W-1:0] arg = '0;
   logic             busy, done, arg_err;
   logic [RES_W-1:0] fib_out;

   int checks = 0;
   int errors = 0;
   bit over = 1'b0;

   always #10 clk = ~clk;

   fibcont_engine #(
      .ARG_W (ARG_W), .RES_W (RES_W), .DEPTH (DEPTH), .N_MAX (N_MAX)
   ) u0 (
      .clk (clk), .rst_n (rst_n), .start (start), .arg (arg),
      .busy (busy), .done (done), .arg_err (arg_err), .fib_out (fib_out)
   );

   task automatic check(input bit ok, input string rq, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
      end
   endtask

   // Called at a negedge. Raises start, counts cycles until done.
   task automatic run_job(input int n, input int exp_res, input int exp_lat,
                          input bit exp_err, input int ign_at, input int ign_arg);
      int  cyc = 0;
      bit  busy_ok = 1'b1;
      start = 1'b1;
      arg   = ARG_W'(n);
      do begin
         @(negedge clk);
         cyc++;
         start = 1'b0;
         if (cyc == ign_at) begin          // R6: interfering start while busy
            start = 1'b1;
            arg   = ARG_W'(ign_arg);
         end
         if (!done && !busy) busy_ok = 1'b0;
      end while (!done && cyc < 5000);
      start = 1'b0;
      check(done == 1'b1, "R2 done seen", done, 1);
      check(fib_out == RES_W'(exp_res), "R2 result", fib_out, exp_res);
      check(arg_err == exp_err, exp_err ? "R7 arg_err" : "R2 arg_err", arg_err, exp_err);
      check(cyc == exp_lat, exp_err ? "R7 latency" : "R4 latency", cyc, exp_lat);
      check(busy == 1'b0, "R5 busy low with done", busy, 0);
      if (!exp_err) check(busy_ok, "R5 busy during job", busy_ok, 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      check(done == 0 && busy == 0 && arg_err == 0, "R1 flags in reset",
            {done, busy, arg_err}, 0);
      check(fib_out == 0, "R1 result in reset", fib_out, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(done == 0 && busy == 0 && fib_out == 0, "R1 after release",
            {done, busy}, 0);

      // R2/R4/R5: table walk
      for (int i = 0; i < NV; i++) begin
         run_job(VEC[i][0], VEC[i][1], VEC[i][2], 1'b0, -1, 0);
         @(negedge clk);
      end

      // R3: done is one cycle; result held
      run_job(6, 8, 46, 1'b0, -1, 0);
      for (int k = 0; k < 5; k++) begin
         @(negedge clk);
         check(done == 0, "R3 done single cycle", done, 0);
         check(fib_out == 8, "R3 result held", fib_out, 8);
      end

      // R7: refused arguments; busy stays low
      run_job(0, 0, 1, 1'b1, -1, 0);
      @(negedge clk);
      check(busy == 0 && done == 0, "R7 busy stays low", busy, 0);
      check(arg_err == 1 && fib_out == 0, "R3 error held", arg_err, 1);
      run_job(14, 0, 1, 1'b1, -1, 0);
      @(negedge clk);
      run_job(15, 0, 1, 1'b1, -1, 0);
      @(negedge clk);

      // R6: start while busy ignored
      run_job(10, 55, 328, 1'b0, 20, 3);
      @(negedge clk);

      // R8: start in the done cycle is accepted
      run_job(4, 3, 16, 1'b0, -1, 0);
      run_job(5, 5, 28, 1'b0, -1, 0);      // R8 back-to-back job
      run_job(0, 0, 1, 1'b1, -1, 0);       // R8 refused job right after done
      run_job(3, 2, 10, 1'b0, -1, 0);      // R8 error cleared by new job

      // R1: reset in mid-job returns to idle
      @(negedge clk);
      start = 1'b1; arg = 4'd9;
      @(negedge clk);
      start = 1'b0;
      repeat (10) @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      check(busy == 0 && done == 0 && fib_out == 0, "R1 mid-job reset", busy, 0);
      rst_n = 1'b1;
      @(negedge clk);
      run_job(2, 1, 4, 1'b0, -1, 0);

      if (!over) begin
         over = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!over) begin
         over = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule